// File: doc/BRIEF.md
# Hybrid LDPC Iteration Stopping Controller

This controller sits beside an iterative LDPC decoder that uses a self-corrected min-sum check-node kernel. After each row, the kernel reports two things: how many of that row's messages it erased, and whether that row's parity constraint failed. At the end of every decoding iteration the decoder strobes `iter_end` and says whether the whole syndrome passed. The controller then decides whether the decoder should run another iteration, stop because the codeblock converged, stop because the block looks undecodable, or stop because the iteration budget is spent.

The undecodable test watches the total number of erased messages in each iteration. Whenever an iteration's total is strictly larger than the one before, a rise counter steps up. When that counter goes past the threshold `THRESH`, the block is declared non-convergent. For each iteration the controller also reports the number of satisfied parity constraints. That count is the row count minus the failing rows. When a stop is reached, the controller ignores the decoder until `blk_start` opens the next codeblock.

Top module: `ldpc_stop_ctrl`

## Requirements
- R1: After reset, `status_valid` is 0, `status` is 0 (continue), `iter_count` is 0 and `sat_count` is 0.
- R2: In the cycle after each accepted `iter_end`, `status_valid` is high for exactly one cycle. `iter_count` then holds the number of completed iterations of the current codeblock.
- R3: When `synd_pass` is high with `iter_end`, the reported status is code 1 (converged).
- R4: The erased total of an iteration is the sum of `row_erased` over every `row_valid` cycle, including a row given in the `iter_end` cycle. The rise counter steps only when this total is strictly greater than the previous iteration's total. An equal or smaller total leaves it unchanged.
- R5: The first iteration of a codeblock is never compared, because there is no previous total.
- R6: When the rise counter goes past `THRESH`, the status is code 2 (non-converged). With the default of 12, this happens on the 13th rise.
- R7: When `iter_count` reaches `MAX_ITER` (default 60) and no other stop applies, the status is code 3 (limit reached).
- R8: When several stops fall on the same iteration, converged wins over non-converged, and non-converged wins over limit.
- R9: `sat_count` equals `ROWS` minus the number of `row_valid` cycles with `row_fail` high in that iteration, including the `iter_end` row.
- R10: Once a stop status (codes 1 to 3) has been given, rows and `iter_end` have no effect: `status_valid` stays low and `iter_count` holds until `blk_start`.
- R11: `blk_start` clears the erased totals, the rise counter and the iteration count. The next codeblock starts again at iteration 1, with no comparison on that iteration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| blk_start | input | 1 | Opens a new codeblock and clears all per-block state |
| row_valid | input | 1 | Row result present this cycle |
| row_erased | input | ERASE_W | Erased-message count of the row |
| row_fail | input | 1 | Row parity constraint failed |
| iter_end | input | 1 | Last row of the iteration; decide now |
| synd_pass | input | 1 | Full syndrome passed for this iteration (read with iter_end) |
| status_valid | output | 1 | Decision outputs valid this cycle |
| status | output | 2 | 0 continue, 1 converged, 2 non-converged, 3 limit |
| iter_count | output | $clog2(MAX_ITER+1) | Completed iterations of the codeblock |
| sat_count | output | $clog2(ROWS+1) | Satisfied constraints in the last iteration |

## Verification
Two pairs of stop conditions can land on the same iteration boundary. In the first pair, the syndrome passes on the same iteration that brings the 13th rise, and the bench expects code 1. In the second pair, the block holds its erased total flat for 47 iterations and then raises it on each of the last 13 iterations. The 13th rise therefore falls exactly on iteration 60, and the bench expects code 2 rather than 3. The single-condition runs next to these pairs fix the iteration each stop would have taken alone, so the priority result cannot be confused with an off-by-one in either count.

// File: rtl/ldpc_stop_pkg.sv
package ldpc_stop_pkg;

   typedef enum logic [1:0] {
      ST_RUN   = 2'd0,
      ST_CONV  = 2'd1,
      ST_STALL = 2'd2,
      ST_LIMIT = 2'd3
   } stop_status_e;

endpackage

// File: rtl/erase_tracker.sv
module erase_tracker #(
   parameter int ERASE_W  = 5,
   parameter int SUM_W    = 10,
   parameter bit SATURATE = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               clr,
   input  logic               add_en,
   input  logic [ERASE_W-1:0] add_val,
   input  logic               close,
   input  logic               first,
   output logic               rise
);

   logic [SUM_W-1:0] acc_q;
   logic [SUM_W-1:0] prev_q;
   logic [SUM_W-1:0] addend;
   logic [SUM_W-1:0] total;

   if (SUM_W < ERASE_W) begin : g_bad_width
      $error("erase_tracker: SUM_W must be at least ERASE_W");
   end

   assign addend = add_en ? SUM_W'(add_val) : '0;

   // Variant choice: clamp the running total or let it grow freely
   if (SATURATE) begin : g_sat
      logic [SUM_W:0] wide;
      assign wide  = {1'b0, acc_q} + {1'b0, addend};
      assign total = wide[SUM_W] ? {SUM_W{1'b1}} : wide[SUM_W-1:0];
   end else begin : g_wrap
      assign total = acc_q + addend;
   end

   // Strictly-greater test against the previous iteration's total
   assign rise = !first && (total > prev_q);

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         acc_q  <= '0;
         prev_q <= '0;
      end else if (close) begin
         prev_q <= total;
         acc_q  <= '0;
      end else if (add_en) begin
         acc_q  <= total;
      end
   end

   // R11
   clear_acc_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (acc_q == '0) && (prev_q == '0));

endmodule

// File: rtl/rise_counter.sv
module rise_counter #(
   parameter int THRESH = 12,
   parameter int CNT_W  = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic step,
   input  logic rise,
   output logic over
);

   localparam logic [CNT_W-1:0] CAP = CNT_W'(THRESH + 1);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_after;

   if ((THRESH + 1) >= (1 << CNT_W)) begin : g_bad_width
      $error("rise_counter: CNT_W too narrow for THRESH+1");
   end

   always_comb begin
      cnt_after = cnt_q;
      if (step && rise && (cnt_q < CAP)) begin
         cnt_after = cnt_q + CNT_W'(1);
      end
   end

   assign over = cnt_after > CNT_W'(THRESH);

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         cnt_q <= '0;
      end else if (step) begin
         cnt_q <= cnt_after;
      end
   end

   // R4
   rise_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q != $past(cnt_q)) |-> ((cnt_q == $past(cnt_q) + CNT_W'(1)) || (cnt_q == '0)));

   // R6
   rise_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CAP);

endmodule

// File: rtl/iter_tracker.sv
module iter_tracker #(
   parameter int MAX_ITER = 60,
   parameter int ITER_W   = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              step,
   output logic [ITER_W-1:0] cnt,
   output logic              first,
   output logic              at_limit
);

   localparam logic [ITER_W-1:0] LIM = ITER_W'(MAX_ITER);

   logic [ITER_W-1:0] cnt_q;
   logic [ITER_W-1:0] cnt_after;

   if (MAX_ITER < 1) begin : g_bad_limit
      $error("iter_tracker: MAX_ITER must be positive");
   end

   assign cnt_after = (step && (cnt_q != LIM)) ? cnt_q + ITER_W'(1) : cnt_q;
   assign first     = (cnt_q == '0);
   assign at_limit  = (cnt_after == LIM);
   assign cnt       = cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_after;
      end
   end

   // R7
   iter_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LIM);

endmodule

// File: rtl/fail_tally.sv
module fail_tally #(
   parameter int ROWS   = 16,
   parameter int RCNT_W = 5
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              add,
   input  logic              close,
   output logic [RCNT_W-1:0] sat_after
);

   localparam logic [RCNT_W-1:0] NROWS = RCNT_W'(ROWS);

   logic [RCNT_W-1:0] fails_q;
   logic [RCNT_W-1:0] fails_after;

   if (ROWS < 1 || ROWS >= (1 << RCNT_W)) begin : g_bad_rows
      $error("fail_tally: ROWS out of range for RCNT_W");
   end

   assign fails_after = (add && (fails_q < NROWS)) ? fails_q + RCNT_W'(1) : fails_q;
   assign sat_after   = NROWS - fails_after;

   always_ff @(posedge clk) begin
      if (!rst_n || clr || close) begin
         fails_q <= '0;
      end else begin
         fails_q <= fails_after;
      end
   end

   // R9
   fail_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fails_q <= NROWS);

endmodule

// File: rtl/ldpc_stop_ctrl.sv
module ldpc_stop_ctrl
   import ldpc_stop_pkg::*;
#(
   parameter int ROWS         = 16,
   parameter int ERASE_W      = 5,
   parameter int THRESH       = 12,
   parameter int MAX_ITER     = 60,
   parameter int SUM_W        = ERASE_W + $clog2(ROWS) + 1,
   parameter bit ACC_SATURATE = 1'b1
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          blk_start,
   input  logic                          row_valid,
   input  logic [ERASE_W-1:0]            row_erased,
   input  logic                          row_fail,
   input  logic                          iter_end,
   input  logic                          synd_pass,
   output logic                          status_valid,
   output logic [1:0]                    status,
   output logic [$clog2(MAX_ITER+1)-1:0] iter_count,
   output logic [$clog2(ROWS+1)-1:0]     sat_count
);

   localparam int ITER_W = $clog2(MAX_ITER + 1);
   localparam int RCNT_W = $clog2(ROWS + 1);
   localparam int INC_W  = $clog2(THRESH + 2);

   if (THRESH < 1) begin : g_bad_thresh
      $error("ldpc_stop_ctrl: THRESH must be positive");
   end

   logic              halted_q;
   logic              live;
   logic              row_go;
   logic              close;
   logic              first;
   logic              rise;
   logic              over;
   logic              at_limit;
   logic [RCNT_W-1:0] sat_after;
   stop_status_e      verdict;
   stop_status_e      status_q;
   logic              valid_q;
   logic [RCNT_W-1:0] sat_q;

   assign live   = !halted_q && !blk_start;
   assign row_go = row_valid && live;
   assign close  = iter_end && live;

   erase_tracker #(
      .ERASE_W (ERASE_W),
      .SUM_W   (SUM_W),
      .SATURATE(ACC_SATURATE)
   ) u_erase (
      .clk    (clk),
      .rst_n  (rst_n),
      .clr    (blk_start),
      .add_en (row_go),
      .add_val(row_erased),
      .close  (close),
      .first  (first),
      .rise   (rise)
   );

   rise_counter #(
      .THRESH(THRESH),
      .CNT_W (INC_W)
   ) u_rise (
      .clk  (clk),
      .rst_n(rst_n),
      .clr  (blk_start),
      .step (close),
      .rise (rise),
      .over (over)
   );

   iter_tracker #(
      .MAX_ITER(MAX_ITER),
      .ITER_W  (ITER_W)
   ) u_iter (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (blk_start),
      .step    (close),
      .cnt     (iter_count),
      .first   (first),
      .at_limit(at_limit)
   );

   fail_tally #(
      .ROWS  (ROWS),
      .RCNT_W(RCNT_W)
   ) u_fail (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (blk_start),
      .add      (row_go && row_fail),
      .close    (close),
      .sat_after(sat_after)
   );

   // Priority: convergence, then stall detection, then budget
   always_comb begin
      if (synd_pass)     verdict = ST_CONV;
      else if (over)     verdict = ST_STALL;
      else if (at_limit) verdict = ST_LIMIT;
      else               verdict = ST_RUN;
   end

   always_ff @(posedge clk) begin
      if (!rst_n || blk_start) begin
         halted_q <= 1'b0;
         valid_q  <= 1'b0;
         status_q <= ST_RUN;
         sat_q    <= '0;
      end else begin
         valid_q <= close;
         if (close) begin
            status_q <= verdict;
            sat_q    <= sat_after;
            halted_q <= (verdict != ST_RUN);
         end
      end
   end

   assign status_valid = valid_q;
   assign status       = status_q;
   assign sat_count    = sat_q;

   // R2
   valid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      status_valid |-> $past(iter_end));

   // R3
   conv_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (status_valid && status == ST_CONV) |-> $past(synd_pass));

   // R7
   limit_iter_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (status_valid && status == ST_LIMIT) |-> (iter_count == ITER_W'(MAX_ITER)));

   // R10
   halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (halted_q && !blk_start) |=> (halted_q && !status_valid && $stable(iter_count)));

endmodule

// File: tb/ldpc_stop_ctrl_test.sv
module ldpc_stop_ctrl_test;

   localparam int CLK_PERIOD = 10;
   localparam int ROWS       = 16;
   localparam int ERASE_W    = 5;
   localparam int MAX_ITER   = 60;
   localparam int WATCHDOG   = 100000;

   localparam int S_RUN   = 0;
   localparam int S_CONV  = 1;
   localparam int S_STALL = 2;
   localparam int S_LIMIT = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic blk_start = 1'b0;
   logic row_valid = 1'b0;
   logic [ERASE_W-1:0] row_erased = '0;
   logic row_fail = 1'b0;
   logic iter_end = 1'b0;
   logic synd_pass = 1'b0;
   logic status_valid;
   logic [1:0] status;
   logic [5:0] iter_count;
   logic [4:0] sat_count;

   int n_checks = 0;
   int n_fails  = 0;
   int cycles   = 0;
   bit done     = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   ldpc_stop_ctrl uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .blk_start   (blk_start),
      .row_valid   (row_valid),
      .row_erased  (row_erased),
      .row_fail    (row_fail),
      .iter_end    (iter_end),
      .synd_pass   (synd_pass),
      .status_valid(status_valid),
      .status      (status),
      .iter_count  (iter_count),
      .sat_count   (sat_count)
   );

   task automatic check(input string req, input string what, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fails++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
         $finish;
      end
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > WATCHDOG && !done) begin
         n_checks++;
         n_fails++;
         $display("FAIL R2 watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
         finish_run();
      end
   end

   // One iteration: ROWS rows, first carries e_first, last (iter_end) carries e_last;
   // the last nfail rows report a parity failure. Returns at the negedge after decision.
   task automatic run_iter(input int e_first, input int e_last, input int nfail, input bit pass);
      for (int r = 0; r < ROWS; r++) begin
         row_valid  = 1'b1;
         row_erased = (r == 0) ? ERASE_W'(e_first) : ((r == ROWS-1) ? ERASE_W'(e_last) : '0);
         row_fail   = (r >= ROWS - nfail);
         iter_end   = (r == ROWS-1);
         synd_pass  = pass && (r == ROWS-1);
         @(negedge clk);
      end
      row_valid  = 1'b0;
      row_erased = '0;
      row_fail   = 1'b0;
      iter_end   = 1'b0;
      synd_pass  = 1'b0;
   endtask

   task automatic new_block();
      blk_start = 1'b1;
      @(negedge clk);
      blk_start = 1'b0;
      // R11: cleared count visible right after the clear
      check("R11", "iter_count after blk_start", int'(iter_count), 0);
   endtask

   task automatic t_reset();
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1", "status_valid", int'(status_valid), 0);
      check("R1", "status", int'(status), S_RUN);
      check("R1", "iter_count", int'(iter_count), 0);
      check("R1", "sat_count", int'(sat_count), 0);
   endtask

   task automatic t_converge_first();
      new_block();
      run_iter(7, 0, 2, 1'b1);
      check("R2", "status_valid", int'(status_valid), 1);
      check("R3", "status converged", int'(status), S_CONV);
      check("R2", "iter_count", int'(iter_count), 1);
      check("R9", "sat_count", int'(sat_count), ROWS - 2);
      @(negedge clk);
      check("R2", "status_valid one cycle", int'(status_valid), 0);
   endtask

   // Rising totals 1..14: iteration 1 uncompared, so the 13th rise is iteration 14
   task automatic t_rise_halt();
      new_block();
      for (int k = 1; k <= 14; k++) begin
         run_iter(k, 0, 0, 1'b0);
         if (k == 13) check("R5", "no stop at iteration 13", int'(status), S_RUN);
         if (k == 14) begin
            check("R6", "stall at 13th rise", int'(status), S_STALL);
            check("R6", "iter_count at stall", int'(iter_count), 14);
            check("R9", "sat_count all pass", int'(sat_count), ROWS);
         end
      end
      run_iter(20, 0, 0, 1'b0);
      check("R10", "no status after halt", int'(status_valid), 0);
      check("R10", "iter_count held", int'(iter_count), 14);
   endtask

   // Alternating totals 2,5,2,5..., the rise carried by the iter_end row
   task automatic t_alt();
      new_block();
      for (int k = 1; k <= 26; k++) begin
         run_iter(2, (k % 2 == 0) ? 3 : 0, 1, 1'b0);
         if (k == 1)  check("R11", "restart at iteration 1", int'(iter_count), 1);
         if (k == 1)  check("R9", "sat_count iter_end row fails", int'(sat_count), ROWS - 1);
         if (k == 25) check("R4", "drops not counted", int'(status), S_RUN);
         if (k == 26) check("R4", "stall via iter_end row", int'(status), S_STALL);
      end
   endtask

   task automatic t_flat_limit();
      new_block();
      for (int k = 1; k <= MAX_ITER; k++) begin
         run_iter(3, 0, 0, 1'b0);
         if (k == MAX_ITER-1) check("R4", "equal totals not counted", int'(status), S_RUN);
         if (k == MAX_ITER) begin
            check("R7", "limit status", int'(status), S_LIMIT);
            check("R7", "iter_count at limit", int'(iter_count), MAX_ITER);
         end
      end
   endtask

   task automatic t_late_rise();
      new_block();
      for (int k = 1; k <= MAX_ITER; k++) begin
         run_iter((k <= 47) ? 1 : k - 46, 0, 0, 1'b0);
         if (k == MAX_ITER-1) check("R8", "still running at 59", int'(status), S_RUN);
         if (k == MAX_ITER)   check("R8", "stall beats limit", int'(status), S_STALL);
      end
   endtask

   task automatic t_conv_vs_stall();
      new_block();
      for (int k = 1; k <= 14; k++) begin
         run_iter(k, 0, 0, k == 14);
         if (k == 14) begin
            check("R8", "converged beats stall", int'(status), S_CONV);
            check("R8", "iter_count", int'(iter_count), 14);
         end
      end
   endtask

   initial begin
      t_reset();
      t_converge_first();
      t_rise_halt();
      t_alt();
      t_flat_limit();
      t_late_rise();
      t_conv_vs_stall();
      finish_run();
   end

endmodule